// File: doc/BRIEF.md
# Phase frequency detector with synchronized power control

This block compares edges from a reference divider with edges from a main (VCO) divider and drives the up (source) and down (sink) controls of a charge pump. Both edge inputs are single-cycle strobes. Whichever edge comes first raises its pulse, and that pulse stays high until the other edge arrives. Once both edges have been seen, up and down are held high together for a fixed window of `OVL_CYC` cycles and then clear on the same clock edge. This common minimum width keeps the detector gain linear when the phase error is close to zero.

A single enable line controls power. When enable is taken high from power-down, the block raises a one-cycle divider-restart request so that the dividers start in phase. When enable is taken low, a pulse that is in progress runs to completion before the block powers down. The charge pump current code is copied from a configuration input, but only while no pulse is active, so the current never changes in the middle of a pulse.

Top module: `pfd_sync`

## Requirements
- R1: With the block powered and idle, a strobe on `ref_edge` alone raises `up` on the next clock edge. `up` stays high until a `main_edge` strobe is sampled, and `down` stays low until then.
- R2: With the block powered and idle, a strobe on `main_edge` alone raises `down` on the next clock edge. `down` stays high until a `ref_edge` strobe is sampled, and `up` stays low until then.
- R3: On the clock edge where the second edge is sampled, both outputs become high. They stay high together for exactly `OVL_CYC` cycles (default 2) and then both clear on the same clock edge.
- R4: If both strobes are sampled in the same cycle while the block is idle, `up` and `down` rise together and are high for exactly `OVL_CYC` cycles.
- R5: During a pulse, a repeat of the edge that started it is ignored. Any strobe sampled during the overlap window is also ignored, so the window length does not change.
- R6: While powered down, `up` and `down` are low and strobes have no effect. The first clock edge that samples `enable` high raises `div_sync` for exactly one cycle, and strobes are accepted from that cycle on. `div_sync` never rises at any other time.
- R7: If `enable` falls while a pulse is active, the pulse completes as normal. Power-down takes effect on the first clock edge that samples `enable` low while both outputs are low, and strobes sampled on that edge are ignored.
- R8: `cp_code` takes the value of `cp_code_in` one cycle later on every clock edge where `up` and `down` are both low. It holds its value on every edge where either output is high.
- R9: While `rst_n` is low, `up`, `down` and `div_sync` are 0, `cp_code` is 0 and the block is powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_edge | input | 1 | Single-cycle strobe from the reference divider |
| main_edge | input | 1 | Single-cycle strobe from the main divider |
| enable | input | 1 | Power request, high = active |
| cp_code_in | input | CODE_W | Charge pump current multiple from configuration |
| up | output | 1 | Source pulse to the charge pump |
| down | output | 1 | Sink pulse to the charge pump |
| cp_code | output | CODE_W | Current multiple applied to the charge pump |
| div_sync | output | 1 | One-cycle request to restart both dividers |

## Verification
The hardest case to reach from the ports is a power-down request that arrives during a pulse, since `enable` has to fall between the first and second edge. Directed steps drop `enable` while `up` is high, then show that the overlap window and clearing still happen. After that they show that strobes are ignored, and that a fresh `div_sync` appears when `enable` returns, which proves the block really did power down. Random stimulus with rare `enable` toggles and frequent strobes gives many more drains of this kind. It also produces edges inside the overlap window, and these are compared cycle by cycle against a reference model in the bench.

// File: rtl/pfd_sync.sv
module pfd_sync #(
  parameter int CODE_W  = 3,
  parameter int OVL_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_edge,
  input  logic              main_edge,
  input  logic              enable,
  input  logic [CODE_W-1:0] cp_code_in,
  output logic              up,
  output logic              down,
  output logic [CODE_W-1:0] cp_code,
  output logic              div_sync
);
  localparam int CNT_W = (OVL_CYC > 1) ? $clog2(OVL_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVL_CYC - 1);

  logic             active;
  logic [CNT_W-1:0] cnt;
  logic             idle;
  logic             both;

  assign idle = !up && !down;
  assign both = up && down;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      up       <= 1'b0;
      down     <= 1'b0;
      cnt      <= '0;
      div_sync <= 1'b0;
      cp_code  <= '0;
    end else begin
      div_sync <= 1'b0;
      if (idle) cp_code <= cp_code_in;
      if (!active) begin
        if (enable) begin
          active   <= 1'b1;
          div_sync <= 1'b1;
        end
      end else if (both) begin
        if (cnt == CNT_LAST) begin
          up   <= 1'b0;
          down <= 1'b0;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (up) begin
        if (main_edge) down <= 1'b1;
      end else if (down) begin
        if (ref_edge) up <= 1'b1;
      end else if (!enable) begin
        active <= 1'b0;
      end else begin
        up   <= ref_edge;
        down <= main_edge;
      end
    end
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!up && !down)); // R6
  AST_SYNC_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    div_sync |-> (active && $past(!active))); // R6
  AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    div_sync |=> !div_sync); // R6
  AST_CLEAR_TOGETHER_UP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(up) |-> $fell(down)); // R3
  AST_CLEAR_TOGETHER_DN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(down) |-> $fell(up)); // R3
  AST_NO_TRUNCATE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> $past(!up && !down)); // R7
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(up || down) |-> $stable(cp_code)); // R8

  generate
    if (OVL_CYC > 1) begin : g_ovl_chk
      AST_OVL_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up && down) |=> (up && down)); // R3
    end
  endgenerate
endmodule

// File: tb/pfd_sync_test.sv
`timescale 1ns/1ps
module pfd_sync_test;
  localparam int CW = 3;
  localparam int OVL = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_edge = 1'b0, main_edge = 1'b0, enable = 1'b0;
  logic [CW-1:0] cp_code_in = '0;
  logic up, down, div_sync;
  logic [CW-1:0] cp_code;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pfd_sync #(.CODE_W(CW), .OVL_CYC(OVL)) uut (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .main_edge(main_edge),
    .enable(enable), .cp_code_in(cp_code_in), .up(up), .down(down),
    .cp_code(cp_code), .div_sync(div_sync));

  typedef enum logic [2:0] {M_OFF, M_IDLE, M_UP, M_DN, M_BOTH} mst_t;
  mst_t m_st = M_OFF;
  int m_win = 0;
  logic m_sync = 1'b0;
  logic [CW-1:0] m_code = '0;

  function automatic logic exp_up(mst_t s);
    return (s == M_UP) || (s == M_BOTH);
  endfunction
  function automatic logic exp_dn(mst_t s);
    return (s == M_DN) || (s == M_BOTH);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= M_OFF; m_win <= 0; m_sync <= 1'b0; m_code <= '0;
    end else begin
      m_sync <= 1'b0;
      if (!exp_up(m_st) && !exp_dn(m_st)) m_code <= cp_code_in;
      case (m_st)
        M_OFF:  if (enable) begin m_st <= M_IDLE; m_sync <= 1'b1; end
        M_IDLE: if (!enable) m_st <= M_OFF;
                else if (ref_edge && main_edge) begin m_st <= M_BOTH; m_win <= 1; end
                else if (ref_edge) m_st <= M_UP;
                else if (main_edge) m_st <= M_DN;
        M_UP:   if (main_edge) begin m_st <= M_BOTH; m_win <= 1; end
        M_DN:   if (ref_edge) begin m_st <= M_BOTH; m_win <= 1; end
        M_BOTH: if (m_win >= OVL) begin m_st <= M_IDLE; m_win <= 0; end
                else m_win <= m_win + 1;
        default: m_st <= M_OFF;
      endcase
    end
  end

  task automatic check(string req, string what, int act, int expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, expv, $time);
    end
  endtask

  task automatic cmp_model();
    check("R1", "up vs model", int'(up), int'(exp_up(m_st)));
    check("R2", "down vs model", int'(down), int'(exp_dn(m_st)));
    check("R6", "div_sync vs model", int'(div_sync), int'(m_sync));
    check("R8", "cp_code vs model", int'(cp_code), int'(m_code));
  endtask

  task automatic tick(input logic r, input logic m, input logic e, input logic [CW-1:0] c);
    ref_edge = r; main_edge = m; enable = e; cp_code_in = c;
    @(negedge clk);
    cmp_model();
  endtask

  task automatic expect_ud(string req, logic eu, logic ed);
    check(req, "up", int'(up), int'(eu));
    check(req, "down", int'(down), int'(ed));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    int unsigned seed;
    logic e_r;
    logic [CW-1:0] c_r;
    seed = 32'd12345;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    expect_ud("R9", 1'b0, 1'b0);
    check("R9", "div_sync", int'(div_sync), 0);
    check("R9", "cp_code", int'(cp_code), 0);
    rst_n = 1'b1;
    @(negedge clk);

    tick(1, 1, 0, 3'd0); expect_ud("R6", 0, 0);
    tick(0, 0, 1, 3'd0); check("R6", "wake sync", int'(div_sync), 1);
    tick(0, 0, 1, 3'd0); check("R6", "sync single", int'(div_sync), 0);

    tick(1, 0, 1, 3'd0); expect_ud("R1", 1, 0);
    tick(0, 0, 1, 3'd0); expect_ud("R1", 1, 0);
    tick(1, 0, 1, 3'd0); expect_ud("R5", 1, 0);
    tick(0, 1, 1, 3'd0); expect_ud("R3", 1, 1);
    tick(0, 0, 1, 3'd0); expect_ud("R3", 1, 1);
    tick(0, 0, 1, 3'd0); expect_ud("R3", 0, 0);

    tick(0, 1, 1, 3'd0); expect_ud("R2", 0, 1);
    tick(0, 1, 1, 3'd0); expect_ud("R5", 0, 1);
    tick(1, 0, 1, 3'd0); expect_ud("R2", 1, 1);
    tick(0, 0, 1, 3'd0); expect_ud("R3", 1, 1);
    tick(0, 0, 1, 3'd0); expect_ud("R3", 0, 0);

    tick(1, 1, 1, 3'd0); expect_ud("R4", 1, 1);
    tick(1, 1, 1, 3'd0); expect_ud("R5", 1, 1);
    tick(0, 0, 1, 3'd0); expect_ud("R4", 0, 0);

    tick(0, 0, 1, 3'd5); check("R8", "idle follow", int'(cp_code), 5);
    tick(1, 0, 1, 3'd6); check("R8", "update on start edge", int'(cp_code), 6);
    tick(0, 0, 1, 3'd2); check("R8", "held in pulse", int'(cp_code), 6);
    tick(0, 1, 1, 3'd2); check("R8", "held in overlap", int'(cp_code), 6);
    tick(0, 0, 1, 3'd2);
    tick(0, 0, 1, 3'd2); check("R8", "held on clear", int'(cp_code), 6);
    tick(0, 0, 1, 3'd2); check("R8", "follow after pulse", int'(cp_code), 2);

    tick(1, 0, 1, 3'd2); expect_ud("R7", 1, 0);
    tick(0, 0, 0, 3'd2); expect_ud("R7", 1, 0);
    tick(0, 1, 0, 3'd2); expect_ud("R7", 1, 1);
    tick(0, 0, 0, 3'd2); expect_ud("R7", 1, 1);
    tick(0, 0, 0, 3'd2); expect_ud("R7", 0, 0);
    tick(1, 0, 0, 3'd2); expect_ud("R7", 0, 0);
    tick(1, 1, 0, 3'd2); expect_ud("R6", 0, 0);
    tick(0, 0, 1, 3'd2); check("R7", "re-wake sync", int'(div_sync), 1);

    e_r = 1'b1;
    c_r = 3'd2;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(49) == 0) e_r = ~e_r;
      if ($urandom_range(7) == 0) c_r = CW'($urandom);
      tick(logic'($urandom_range(5) == 0), logic'($urandom_range(5) == 0), e_r, c_r);
    end
    finish_run();
  end
endmodule